// File: doc/BRIEF.md
# Decade-Step Sample Rate Generator

This block produces the sample strobe that starts one simultaneous conversion of every input channel. In its internal mode it divides the system clock down to one of seventeen rates. Codes 0 to 15 follow a 1-2-5 progression per decade, from 1 Hz up to 100 kHz, and code 16 selects 160 kHz. The divide count for each code is computed at elaboration from the system clock frequency parameter. For example, a 32 MHz clock and the 160 kHz code give a count of 200.

In its external mode the strobe comes from rising edges of an asynchronous clock pin. The pin passes through a two-flop synchronizer and an edge detector. The strobe is suppressed in both modes while arm is low.

Some codes cannot be used. A code above 16 is invalid. The 160 kHz code is invalid when the system clock is slower than a configurable minimum, which defaults to 32 MHz. In either case a rate-invalid flag is raised and the divider runs at the fastest rate that is allowed.

Top module: `sample_rate_gen`

## Requirements
- R1: While reset is high and on the first cycle after it, `sample_strobe` and `rate_invalid` are 0.
- R2: With arm set and the external mode off, consecutive strobes are exactly SYS_CLK_HZ / rate(code) cycles apart, and each strobe is high for one cycle only.
- R3: rate(code) for codes 0..15 is m·10^k, where k = code/3 and m is 1, 2 or 5 for code%3 = 0, 1 or 2. Code 16 gives 160 000 Hz. `rate_invalid` is 0 one cycle after any code of 15 or less is presented.
- R4: While arm is low no strobe is produced. When arm rises with the code held, the first strobe appears P cycles later, where P is the current period.
- R5: A change of `rate_code` while armed reloads the divider at once. The next strobe appears P'+1 cycles after the change, where P' is the new period.
- R6: In the external mode a rising edge on `ext_clk_async` gives a one-cycle strobe 3 clock edges later. Falling edges and a steady level give none.
- R7: While the external mode is selected, the internal divider produces no strobes.
- R8: A code above 16 sets `rate_invalid` one cycle later, and the divider runs at the highest valid rate.
- R9: Code 16 with SYS_CLK_HZ below TOP_RATE_MIN_CLK_HZ sets `rate_invalid` and runs the divider at the 100 kHz period.
- R10: In the external mode with arm low, external rising edges produce no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_code | input | CODE_W (5) | Rate selection code |
| ext_clk_sel | input | 1 | 1 = strobe from external clock edges |
| arm | input | 1 | Enables strobe generation |
| ext_clk_async | input | 1 | Asynchronous external sample clock |
| sample_strobe | output | 1 | One-cycle sample start pulse |
| rate_invalid | output | 1 | Code unusable at this system clock; fallback in use |

## Verification
The bench measures exact strobe spacing at several codes and the exact latency from arm rising and from a code change. A divider with an off-by-one count, or one that ignored a code change until its old count ran out, would miss these counts by a cycle or by a whole period. It drives the external pin with a high level, a low level and a falling edge. A detector that fires on levels or on falling edges would produce extra strobes, and a leaky internal path would add periodic strobes. A second instance with a higher minimum clock checks that the 160 kHz code falls back to the 100 kHz period with the flag raised instead of running too fast.

// File: rtl/srg_pkg.sv
package srg_pkg;

    localparam int unsigned NUM_CODES = 17;
    localparam int unsigned TOP_CODE  = 16;
    localparam longint unsigned TOP_RATE_HZ = 64'd160_000;

    // Sample rate in Hz for a table code (1-2-5 per decade, top code fixed)
    function automatic longint unsigned code_rate_hz(int unsigned code);
        longint unsigned mant;
        longint unsigned scale;
        if (code == TOP_CODE) begin
            return TOP_RATE_HZ;
        end
        case (code % 3)
            0:       mant = 64'd1;
            1:       mant = 64'd2;
            default: mant = 64'd5;
        endcase
        scale = 64'd1;
        for (int unsigned i = 0; i < code / 3; i++) begin
            scale = scale * 64'd10;
        end
        return mant * scale;
    endfunction

    // Divide count for a code at a given system clock, never below one
    function automatic longint unsigned code_period(longint unsigned sys_hz,
                                                    int unsigned code);
        longint unsigned p;
        p = sys_hz / code_rate_hz(code);
        if (p == 64'd0) begin
            p = 64'd1;
        end
        return p;
    endfunction

endpackage

// File: rtl/srg_rate_lookup.sv
module srg_rate_lookup #(
    parameter longint unsigned SYS_CLK_HZ          = 64'd32_000_000,
    parameter longint unsigned TOP_RATE_MIN_CLK_HZ = 64'd32_000_000,
    parameter int unsigned     CODE_W              = 5,
    parameter int unsigned     CNT_W               = 25
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [CNT_W-1:0]  period_o,
    output logic              bad_o
);
    import srg_pkg::*;

    localparam bit          TOP_OK   = (SYS_CLK_HZ >= TOP_RATE_MIN_CLK_HZ);
    localparam int unsigned BEST_OK  = TOP_OK ? TOP_CODE : TOP_CODE - 1;

    logic [CNT_W-1:0] period_tab [NUM_CODES];

    for (genvar g = 0; g < NUM_CODES; g++) begin : g_tab
        assign period_tab[g] = CNT_W'(code_period(SYS_CLK_HZ, g));
    end

    typedef struct packed {
        logic [CODE_W-1:0] idx;
        logic              bad;
    } pick_t;

    pick_t pick_d;

    always_comb begin
        pick_d.idx = code_i;
        pick_d.bad = 1'b0;
        if (code_i > CODE_W'(TOP_CODE)) begin
            pick_d.idx = CODE_W'(BEST_OK);
            pick_d.bad = 1'b1;
        end else if (code_i == CODE_W'(TOP_CODE) && !TOP_OK) begin
            pick_d.idx = CODE_W'(TOP_CODE - 1);
            pick_d.bad = 1'b1;
        end
    end

    assign period_o = period_tab[pick_d.idx];
    assign bad_o    = pick_d.bad;

endmodule

// File: rtl/srg_divider.sv
module srg_divider #(
    parameter int unsigned CODE_W = 5,
    parameter int unsigned CNT_W  = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [CNT_W-1:0]  period_i,
    output logic              tick_o
);
    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [CODE_W-1:0] code;
        logic              tick;
    } div_t;

    div_t q, d;

    always_comb begin
        d      = q;
        d.code = code_i;
        d.tick = 1'b0;
        if (!run_i || code_i != q.code) begin
            d.cnt = period_i - CNT_W'(1);
        end else if (q.cnt == '0) begin
            d.tick = 1'b1;
            d.cnt  = period_i - CNT_W'(1);
        end else begin
            d.cnt = q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign tick_o = q.tick;

    // R4: an idle divider never ticks
    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> !q.tick);

    // R5: a new code reloads the counter from the new period at once
    a_r5_reload_on_change: assert property (@(posedge clk) disable iff (rst)
        (run_i && code_i != q.code) |=> (!q.tick && q.cnt == $past(period_i) - CNT_W'(1)));

    // R2: a tick only follows an exhausted count
    a_r2_tick_from_zero: assert property (@(posedge clk) disable iff (rst)
        q.tick |-> ($past(q.cnt) == '0 && $past(run_i)));

endmodule

// File: rtl/srg_edge_sync.sv
module srg_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic pulse_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
        logic pulse;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d.s1    = async_i;
        d.s2    = q.s1;
        d.prev  = q.s2;
        d.pulse = q.s2 & ~q.prev;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign pulse_o = q.pulse;

    // R6: one rising edge yields exactly one pulse cycle
    a_r6_pulse_one_cycle: assert property (@(posedge clk) disable iff (rst)
        q.pulse |=> !q.pulse);

endmodule

// File: rtl/sample_rate_gen.sv
module sample_rate_gen #(
    parameter longint unsigned SYS_CLK_HZ          = 64'd32_000_000,
    parameter longint unsigned TOP_RATE_MIN_CLK_HZ = 64'd32_000_000,
    parameter int unsigned     CODE_W              = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] rate_code,
    input  logic              ext_clk_sel,
    input  logic              arm,
    input  logic              ext_clk_async,
    output logic              sample_strobe,
    output logic              rate_invalid
);
    localparam int unsigned CNT_W = $clog2(SYS_CLK_HZ + 64'd1);

    logic [CNT_W-1:0] period;
    logic             code_bad;
    logic             div_tick;
    logic             ext_pulse;
    logic             div_run;

    typedef struct packed {
        logic invalid;
    } top_t;

    top_t q, d;

    srg_rate_lookup #(
        .SYS_CLK_HZ          (SYS_CLK_HZ),
        .TOP_RATE_MIN_CLK_HZ (TOP_RATE_MIN_CLK_HZ),
        .CODE_W              (CODE_W),
        .CNT_W               (CNT_W)
    ) u_lookup (
        .code_i   (rate_code),
        .period_o (period),
        .bad_o    (code_bad)
    );

    assign div_run = arm & ~ext_clk_sel;

    srg_divider #(
        .CODE_W (CODE_W),
        .CNT_W  (CNT_W)
    ) u_div (
        .clk      (clk),
        .rst      (rst),
        .run_i    (div_run),
        .code_i   (rate_code),
        .period_i (period),
        .tick_o   (div_tick)
    );

    srg_edge_sync u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (ext_clk_async),
        .pulse_o (ext_pulse)
    );

    always_comb begin
        d.invalid = code_bad;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sample_strobe = arm & (ext_clk_sel ? ext_pulse : div_tick);
    assign rate_invalid  = q.invalid;

    // R8: codes beyond the table raise the flag on the next cycle
    a_r8_invalid_flag: assert property (@(posedge clk) disable iff (rst)
        (rate_code > CODE_W'(16)) |=> rate_invalid);

    // R3: table codes below the top code are always valid
    a_r3_valid_clear: assert property (@(posedge clk) disable iff (rst)
        (rate_code < CODE_W'(16)) |=> !rate_invalid);

    // R7: the divider stays silent while external mode is held
    a_r7_divider_muted: assert property (@(posedge clk) disable iff (rst)
        (ext_clk_sel && $past(ext_clk_sel)) |-> !div_tick);

endmodule

// File: tb/tb_sample_rate_gen.sv
module tb_sample_rate_gen;

    localparam longint unsigned SYS_HZ = 64'd1_600_000;
    localparam int LIMIT = 40000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] code = 5'd0;
    logic       ext_sel = 1'b0;
    logic       arm = 1'b0;
    logic       ext_clk = 1'b0;
    logic       strobe_f, strobe_s, inval_f, inval_s;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    sample_rate_gen #(.SYS_CLK_HZ(SYS_HZ), .TOP_RATE_MIN_CLK_HZ(SYS_HZ)) dut (
        .clk(clk), .rst(rst), .rate_code(code), .ext_clk_sel(ext_sel), .arm(arm),
        .ext_clk_async(ext_clk), .sample_strobe(strobe_f), .rate_invalid(inval_f));

    sample_rate_gen #(.SYS_CLK_HZ(SYS_HZ), .TOP_RATE_MIN_CLK_HZ(64'd32_000_000)) dut_slow (
        .clk(clk), .rst(rst), .rate_code(code), .ext_clk_sel(ext_sel), .arm(arm),
        .ext_clk_async(ext_clk), .sample_strobe(strobe_s), .rate_invalid(inval_s));

    function automatic int exp_rate(int c);
        case (c)
            0: return 1;       1: return 2;       2: return 5;
            3: return 10;      4: return 20;      5: return 50;
            6: return 100;     7: return 200;     8: return 500;
            9: return 1000;    10: return 2000;   11: return 5000;
            12: return 10000;  13: return 20000;  14: return 50000;
            15: return 100000; default: return 160000;
        endcase
    endfunction

    function automatic int exp_period(int c);
        return int'(SYS_HZ) / exp_rate(c);
    endfunction

    function automatic logic st(bit w);
        return w ? strobe_s : strobe_f;
    endfunction

    task automatic check(bit ok, string tag, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic wait_strobe(bit w, output bit found);
        found = 1'b0;
        for (int i = 0; i < LIMIT; i++) begin
            @(negedge clk);
            if (st(w)) begin
                found = 1'b1;
                break;
            end
        end
    endtask

    task automatic measure(bit w, int expv, string tag);
        bit found;
        int n;
        wait_strobe(w, found);
        check(found, {tag, " first strobe"}, int'(found), 1);
        @(negedge clk);
        check(!st(w), {tag, " width"}, int'(st(w)), 0);
        n = 1;
        while (!st(w) && n < LIMIT) begin
            @(negedge clk);
            n++;
        end
        check(n == expv, {tag, " interval"}, n, expv);
    endtask

    task automatic count_strobes(bit w, int cycles, output int cnt);
        cnt = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (st(w)) cnt++;
        end
    endtask

    task automatic t_reset;
        rst = 1'b1; arm = 1'b0; ext_sel = 1'b0; code = 5'd16;
        repeat (4) @(negedge clk);
        check(!strobe_f && !inval_f, "R1 in reset", int'(strobe_f | inval_f), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!strobe_f && !inval_f && !strobe_s, "R1 after reset",
              int'(strobe_f | inval_f | strobe_s), 0);
    endtask

    task automatic t_intervals;
        int codes [5] = '{16, 15, 13, 10, 9};
        arm = 1'b1;
        foreach (codes[i]) begin
            code = 5'(codes[i]);
            @(negedge clk);
            check(!inval_f, "R3 valid flag", int'(inval_f), 0);
            measure(1'b0, exp_period(codes[i]), "R2 R3");
        end
    endtask

    task automatic t_arm;
        int cnt;
        int n;
        arm = 1'b0; ext_sel = 1'b0; code = 5'd15;
        count_strobes(1'b0, 100, cnt);
        check(cnt == 0, "R4 disarmed strobes", cnt, 0);
        arm = 1'b1;
        n = 0;
        while (!strobe_f && n < LIMIT) begin
            @(negedge clk);
            n++;
        end
        check(n == exp_period(15), "R4 arm latency", n, exp_period(15));
    endtask

    task automatic t_code_change;
        bit found;
        int n;
        code = 5'd14; arm = 1'b1;
        @(negedge clk);
        wait_strobe(1'b0, found);
        check(found, "R5 strobe before change", int'(found), 1);
        repeat (5) @(negedge clk);
        code = 5'd13;
        n = 0;
        while (!strobe_f && n < LIMIT) begin
            @(negedge clk);
            n++;
        end
        check(n == exp_period(13) + 1, "R5 reload latency", n, exp_period(13) + 1);
    endtask

    task automatic t_invalid;
        code = 5'd20; arm = 1'b1;
        @(negedge clk);
        check(inval_f == 1'b1, "R8 flag", int'(inval_f), 1);
        measure(1'b0, exp_period(16), "R8 fallback");
        code = 5'd16;
        @(negedge clk);
        check(inval_s == 1'b1, "R9 slow flag", int'(inval_s), 1);
        check(inval_f == 1'b0, "R9 fast clock top code valid", int'(inval_f), 0);
        measure(1'b1, exp_period(15), "R9 fallback");
        code = 5'd15;
        @(negedge clk);
        check(inval_s == 1'b0, "R3 slow flag clears", int'(inval_s), 0);
    endtask

    task automatic t_external;
        int cnt;
        int n;
        code = 5'd16; ext_clk = 1'b0; arm = 1'b1; ext_sel = 1'b1;
        count_strobes(1'b0, 50, cnt);
        check(cnt == 0, "R7 no internal strobes", cnt, 0);
        ext_clk = 1'b1;
        n = 0;
        while (!strobe_f && n < 50) begin
            @(negedge clk);
            n++;
        end
        check(n == 3, "R6 edge latency", n, 3);
        @(negedge clk);
        check(!strobe_f, "R6 width", int'(strobe_f), 0);
        count_strobes(1'b0, 20, cnt);
        check(cnt == 0, "R6 steady high", cnt, 0);
        ext_clk = 1'b0;
        count_strobes(1'b0, 10, cnt);
        check(cnt == 0, "R6 falling edge", cnt, 0);
        ext_clk = 1'b1;
        count_strobes(1'b0, 10, cnt);
        check(cnt == 1, "R6 second edge", cnt, 1);
        ext_clk = 1'b0;
        repeat (5) @(negedge clk);
        arm = 1'b0;
        ext_clk = 1'b1;
        count_strobes(1'b0, 10, cnt);
        check(cnt == 0, "R10 disarmed external", cnt, 0);
        ext_sel = 1'b0;
    endtask

    initial begin
        t_reset();
        t_intervals();
        t_arm();
        t_code_change();
        t_invalid();
        t_external();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule